// File: doc/BRIEF.md
# Poly1305 Block Accumulator

This block performs the per-block arithmetic of the Poly1305 one-time authenticator. Each loaded 16-byte message word is added to a 130-bit running accumulator, and the sum is multiplied by the clamped key half `r` modulo the prime 2^130 - 5. The 128-bit tag is the low half of the accumulator plus the key half `s`, so the caller can read it after the last block of a message.

The multiply does not use a single wide product. It is split into 32-bit limbs of `r`, and one partial product is added per clock. A final cycle then folds the product twice by the factor 5 and fully reduces it below the modulus. The caller assembles each block, including the 0x01 separator byte and zero padding for a short final block. It raises `ld` for one cycle and waits for the one-cycle `rdy` pulse.

Top module: `poly1305_blk`

## Requirements
- R1: The key half `r_key` is ANDed with 0x0FFFFFFC0FFFFFFC0FFFFFFC0FFFFFFF before use, so key bits outside this mask have no effect on the result.
- R2: With `full_blk`=1 the addend is `msg` + 2^128. With `full_blk`=0 the addend is `msg` unchanged, because it already carries the separator byte and padding.
- R3: With `first`=1 the stored accumulator is replaced by zero as the addend base, which starts a new message.
- R4: A block sets the accumulator to ((base + addend) × clamped r) mod (2^130 - 5), fully reduced, so it always stays below 2^130 - 5.
- R5: `tag` equals the low 128 bits of (accumulator + `s_key`), and it reflects a block's result from the cycle after its `rdy` pulse.
- R6: `rdy` is a single-cycle pulse. It is high in the cycle after the fourth rising edge that follows the edge sampling an accepted `ld` (default 32-bit limbs).
- R7: An `ld` that arrives while a block is in progress is ignored. The running block keeps its operands and its timing.
- R8: A synchronous active-high `rst` clears the accumulator and abandons any block in progress. No `rdy` follows, and `tag` equals `s_key`.
- R9: The accumulator, and so `tag` for a fixed `s_key`, changes only on the edge where `rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| r_key | input | 128 | Multiplier key half, clamped internally, sampled with `ld` |
| s_key | input | 128 | Key half added to form the tag |
| msg | input | 128 | Message word, little-endian number, sampled with `ld` |
| full_blk | input | 1 | 1 = full 16-byte block, adds bit 128 |
| ld | input | 1 | Start a block when idle |
| first | input | 1 | 1 = first block of a message, accumulator base is zero |
| tag | output | 128 | Accumulator plus `s_key`, low 128 bits |
| rdy | output | 1 | One-cycle pulse when a block completes |

## Verification
The assertions assume that `ld` has meaning only while the block is idle. They also assume that reset is synchronous and held for at least one edge, and that `r_key`, `msg`, `full_blk` and `first` need only be valid at the accepting edge. `s_key` feeds the tag combinationally, so the stimulus holds `s_key` constant from the start of a block until its tag has been sampled. Inputs change only on falling edges. The one test that drives `ld` during a running block releases it before `rdy`, so the assertions never see a new block accepted in the completion cycle.

// File: rtl/poly1305_blk.sv
module poly1305_blk #(
  parameter int LIMB_W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [127:0] r_key,
  input  logic [127:0] s_key,
  input  logic [127:0] msg,
  input  logic         full_blk,
  input  logic         ld,
  input  logic         first,
  output logic [127:0] tag,
  output logic         rdy
);
  localparam int NLIMB = 128 / LIMB_W;
  localparam int IW    = (NLIMB > 1) ? $clog2(NLIMB) : 1;
  localparam int SW    = $clog2(NLIMB + 1);
  localparam int XW    = 131;
  localparam int PW    = XW + 128;
  localparam int PPW   = XW + LIMB_W;
  localparam logic [127:0] CLAMP = 128'h0FFFFFFC_0FFFFFFC_0FFFFFFC_0FFFFFFF;
  localparam logic [130:0] PMOD  = (131'd1 << 130) - 131'd5;

  logic          busy;
  logic [SW-1:0] step;
  logic [XW-1:0] x_q;
  logic [127:0]  r_q;
  logic [PW-1:0] prod;
  logic [129:0]  acc_q;

  logic [IW-1:0]     lidx;
  logic [LIMB_W-1:0] limb;
  logic [PPW-1:0]    pp;
  logic [PW-1:0]     pp_sh;
  logic [XW-1:0]     x_d;
  logic [131:0]      f1;
  logic [130:0]      f2;
  logic [129:0]      acc_d;
  logic              start, done;

  assign lidx  = step[IW-1:0];
  assign limb  = r_q[lidx*LIMB_W +: LIMB_W];
  assign pp    = PPW'(x_q) * PPW'(limb);
  assign pp_sh = PW'(pp) << (LIMB_W * lidx);

  assign x_d   = XW'(first ? 130'd0 : acc_q) + XW'({full_blk, msg});

  assign f1    = 132'(prod[129:0]) + 132'(prod[PW-1:130]) * 132'd5;
  assign f2    = 131'(f1[129:0]) + 131'(f1[131:130]) * 131'd5;
  assign acc_d = (f2 >= PMOD) ? 130'(f2 - PMOD) : f2[129:0];

  assign start = ld && !busy;
  assign done  = busy && (step == SW'(NLIMB));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      x_q   <= '0;
      r_q   <= '0;
      prod  <= '0;
      acc_q <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
      prod <= '0;
      x_q  <= x_d;
      r_q  <= r_key & CLAMP;
    end else if (busy) begin
      if (done) begin
        busy  <= 1'b0;
        acc_q <= acc_d;
      end else begin
        prod <= prod + pp_sh;
        step <= step + SW'(1);
      end
    end
  end

  assign rdy = done;
  assign tag = acc_q[127:0] + s_key;
endmodule

// File: rtl/poly1305_blk_chk.sv
module poly1305_blk_chk #(
  parameter int NLIMB = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ld,
  input logic         busy,
  input logic         rdy,
  input logic [129:0] acc
);
  localparam logic [129:0] PMOD = 130'h3_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFB;

  logic [7:0] since_ld;

  always_ff @(posedge clk) begin
    if (rst)                since_ld <= '0;
    else if (ld && !busy)   since_ld <= 8'd1;
    else if (rdy)           since_ld <= '0;
    else if (since_ld != 0) since_ld <= since_ld + 8'd1;
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) rdy |-> (int'(since_ld) == NLIMB + 1)); // R6
  AST_RDY_PULSE:    assert property (@(posedge clk) disable iff (rst) rdy |=> !rdy); // R6
  AST_ACC_HOLD:     assert property (@(posedge clk) disable iff (rst) !rdy |=> $stable(acc)); // R9
  AST_ACC_BELOW_P:  assert property (@(posedge clk) disable iff (rst) acc < PMOD); // R4
  AST_BUSY_HOLD:    assert property (@(posedge clk) disable iff (rst) (busy && !rdy) |=> busy); // R7
endmodule

bind poly1305_blk poly1305_blk_chk #(.NLIMB(NLIMB)) u_chk (
  .clk(clk), .rst(rst), .ld(ld), .busy(busy), .rdy(rdy), .acc(acc_q)
);

// File: tb/poly1305_blk_bench.sv
module poly1305_blk_bench;
  localparam logic [127:0] CLAMP  = 128'h0FFFFFFC_0FFFFFFC_0FFFFFFC_0FFFFFFF;
  localparam logic [129:0] PM     = 130'h3_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFB;
  localparam logic [127:0] RFC_R  = 128'ha806d542_fe52447f_336d5557_78bed685;
  localparam logic [127:0] RFC_S  = 128'h1bf54941_aff6bf4a_fdb20dfb_8a800301;
  localparam logic [127:0] RFC_T  = 128'ha927010c_af8b2bc2_c6365130_c11d06a8;
  localparam logic [127:0] ONES   = {128{1'b1}};
  localparam int NV = 7;
  localparam int LAT = 4;

  // {first, full_blk, r, s, msg}
  localparam logic [385:0] VEC [NV] = '{
    {1'b1, 1'b1, RFC_R, RFC_S, 128'h6f462063_69687061_72676f74_70797243},
    {1'b0, 1'b1, RFC_R, RFC_S, 128'h6f724720_68637261_65736552_206d7572},
    {1'b0, 1'b0, RFC_R, RFC_S, 128'h00000000_00000000_00000000_00017075},
    {1'b1, 1'b1, 128'd1, 128'd0, ONES},
    {1'b0, 1'b1, 128'd1, 128'd0, ONES},
    {1'b1, 1'b0, ONES, ONES, 128'h00000000_00000000_00000001_abcdef12},
    {1'b0, 1'b1, ONES, ONES, 128'h3c9a_51f0_7e22_d481_9b06_c3e5_1177_a0f4}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [127:0] r_key = '0, s_key = '0, msg = '0;
  logic full_blk = 1'b0, ld = 1'b0, first = 1'b0;
  logic [127:0] tag;
  logic rdy;

  int checks = 0, fails = 0;
  logic [129:0] acc_m = '0;

  always #2.5 clk = ~clk;

  poly1305_blk u_poly1305_blk (
    .clk(clk), .rst(rst), .r_key(r_key), .s_key(s_key), .msg(msg),
    .full_blk(full_blk), .ld(ld), .first(first), .tag(tag), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic f, input logic fb, input logic [127:0] r, input logic [127:0] m);
    logic [259:0] t;
    logic [129:0] base;
    base = f ? 130'd0 : acc_m;
    t = (260'(base) + 260'({fb, m})) * 260'(r & CLAMP);
    acc_m = 130'(t % 260'(PM));
  endtask

  task automatic run_block(input logic f, input logic fb, input logic [127:0] r,
                           input logic [127:0] s, input logic [127:0] m);
    int k;
    first = f; full_blk = fb; r_key = r; s_key = s; msg = m; ld = 1'b1;
    @(posedge clk); @(negedge clk);
    ld = 1'b0;
    k = 0;
    while (!rdy && k < 20) begin @(posedge clk); @(negedge clk); k++; end
    chk("R6 latency", 128'(k), 128'(LAT));
    model(f, fb, r, m);
    @(posedge clk); @(negedge clk);
    chk("R6 pulse", 128'(rdy), 128'd0);
    chk("R4/R5 tag", tag, acc_m[127:0] + s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] tag_v0, tag0;
    int k;
    s_key = RFC_S;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R8 reset rdy", 128'(rdy), 128'd0);
    chk("R8 reset tag", tag, RFC_S);

    tag_v0 = '0;
    for (int i = 0; i < NV; i++) begin
      run_block(VEC[i][385], VEC[i][384], VEC[i][383:256], VEC[i][255:128], VEC[i][127:0]);
      if (i == 0) tag_v0 = tag;
      if (i == 2) chk("R2/R4 known tag", tag, RFC_T);
      if (i == 3) chk("R2 full bit", tag, ONES);
      if (i == 4) chk("R4 full reduction", tag, 128'd3);
    end

    // R1: pre-clamped key gives same tag as raw key
    run_block(1'b1, 1'b1, RFC_R & CLAMP, RFC_S, VEC[0][127:0]);
    chk("R1 clamp", tag, tag_v0);

    // R7 / R9: ld during a running block is ignored, tag holds
    tag0 = tag;
    first = 1'b0; full_blk = 1'b1; r_key = RFC_R; s_key = RFC_S;
    msg = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210; ld = 1'b1;
    @(posedge clk); @(negedge clk);
    first = 1'b1; full_blk = 1'b0; msg = ONES; r_key = ONES;
    @(posedge clk); @(negedge clk);
    chk("R9 tag held", tag, tag0);
    @(posedge clk); @(negedge clk);
    ld = 1'b0;
    k = 2;
    while (!rdy && k < 20) begin @(posedge clk); @(negedge clk); k++; end
    chk("R7 latency kept", 128'(k), 128'(LAT));
    chk("R9 tag at rdy", tag, tag0);
    model(1'b0, 1'b1, RFC_R, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    @(posedge clk); @(negedge clk);
    chk("R7 operands kept", tag, acc_m[127:0] + RFC_S);

    // R8: reset mid-block
    first = 1'b0; full_blk = 1'b1; msg = ONES; ld = 1'b1;
    @(posedge clk); @(negedge clk);
    ld = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    k = 0;
    for (int c = 0; c < 8; c++) begin
      if (rdy) k++;
      @(posedge clk); @(negedge clk);
    end
    chk("R8 no rdy", 128'(k), 128'd0);
    chk("R8 tag is s", tag, RFC_S);
    acc_m = '0;

    // R3/R8: after reset, first=0 equals a first=1 start
    run_block(1'b0, 1'b1, RFC_R, RFC_S, VEC[0][127:0]);
    chk("R3 zero base", tag, tag_v0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule